// File: doc/BRIEF.md
# Limb-Serial Bigint Multiply-Accumulate

This block multiplies an unsigned big integer, held as a series of 64-bit limbs, by one 64-bit scalar. Each step forms the 128-bit value limb × multiplier + carry. The low 64 bits leave the block as one result limb. The high 64 bits become the carry for the next limb. The first step uses a carry supplied at start. The carry left after the last limb is returned as the carry-out, which serves as the extra top limb of the product.

A start pulse captures the vector length, the scalar multiplier and the initial carry. Limbs then arrive least significant first on a valid/ready input stream. Results leave, also least significant first, on a valid/ready output stream.

The input stream accepts a limb only in a cycle where both `in_valid` and `in_ready` are high. The output stream hands over a limb only in a cycle where both `out_valid` and `out_ready` are high. While `out_ready` is low, the result is held on `out_limb` with `out_valid` high. The product unit takes several cycles. `in_ready` stays low until the previous result has been taken, so at most one limb is ever in flight.

The control pins `start`, `busy` and `done` are plain levels.

Top module: `limb_mac_seq`

## Requirements
- R1: After reset `busy`, `done`, `in_ready` and `out_valid` are all low.
- R2: Each result limb equals (limb × multiplier + carry) mod 2^64, all unsigned. The carry for the following limb is the same value shifted right by 64.
- R3: Each accepted input limb yields exactly one result limb, in order of arrival. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_limb` does not change.
- R4: `in_ready` is low while a result is waiting on the output or the product unit is working. The next limb is taken only after the current limb's carry has been produced and its result handed over.
- R5: After the handover of the last result limb, `done` is high and `busy` is low from the next cycle on. `carry_out` then equals the high half of the last step.
- R6: A start with vector length 0 raises `done` in the cycle after the start. `carry_out` equals the initial carry, and `in_ready` never rises.
- R7: A start pulse while `busy` is high is ignored. The run in progress keeps its multiplier, carry and length, and `done` stays low until that run ends.
- R8: A vector length above 16 (MAX_LIMBS) is treated as 16. Exactly 16 limbs are taken, then `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; sampled only when idle |
| vlen | input | 5 | Number of limbs, 0 to 31; values above 16 clamp to 16 |
| mult | input | 64 | Scalar multiplier, captured at start |
| carry_in | input | 64 | Initial carry, captured at start |
| in_valid | input | 1 | Input limb present |
| in_ready | output | 1 | Block can take an input limb |
| in_limb | input | 64 | Input limb, least significant first |
| out_valid | output | 1 | Result limb present |
| out_ready | input | 1 | Consumer takes the result limb |
| out_limb | output | 64 | Result limb |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run finished; held until the next accepted start |
| carry_out | output | 64 | Running carry; final carry once `done` is high |

## Verification
The assertions assume that `in_limb` is stable in the cycle it is accepted. They also assume that the consumer never depends on `out_limb` outside a valid cycle. The bench drives each limb only while `in_ready` is high, for exactly one accepted cycle. It raises `out_ready` only once `out_valid` has been seen, sometimes after a stall of several cycles to exercise the hold rule. The bench changes all inputs on the falling edge, so every input is settled well before the rising edge that samples it. Start pulses during a run are deliberately given values different from the running operands, so that any leak of them shows up in the results.

// File: rtl/lmac_pkg.sv
package lmac_pkg;
  typedef enum logic [1:0] {
    S_IDLE,
    S_FETCH,
    S_MUL,
    S_EMIT
  } seq_state_t;
endpackage

// File: rtl/lmac_mul.sv
// Multi-cycle unsigned multiply-add: {hi,lo} = a*b + c, ready LAT cycles after go.
module lmac_mul #(
  parameter int W   = 64,
  parameter int LAT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic         busy,
  output logic         rdy,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  localparam int CW = $clog2(LAT + 1);

  logic [2*W-1:0] acc;
  logic [CW-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      cnt <= '0;
    end else if (go) begin
      acc <= ({{W{1'b0}}, a} * {{W{1'b0}}, b}) + {{W{1'b0}}, c};
      cnt <= CW'(LAT);
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign busy = (cnt != '0);
  assign rdy  = (cnt == CW'(1));
  assign lo   = acc[W-1:0];
  assign hi   = acc[2*W-1:W];

  // R4: a new operand set is only launched into a free unit
  p_go_when_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);

  // R2: each launch yields a single ready pulse
  p_single_rdy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> !rdy);
endmodule

// File: rtl/lmac_ctl.sv
// Limb sequencer: captures operands, streams limbs through the multiply-add unit,
// chains the high half back as the carry.
module lmac_ctl
  import lmac_pkg::*;
#(
  parameter int W     = 64,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic [W-1:0]     mult,
  input  logic [W-1:0]     cin,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_limb,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_limb,
  output logic             busy,
  output logic             done,
  output logic [W-1:0]     carry_out,
  output logic             mul_go,
  output logic [W-1:0]     mul_a,
  output logic [W-1:0]     mul_b,
  output logic [W-1:0]     mul_c,
  input  logic             mul_busy,
  input  logic             mul_rdy,
  input  logic [W-1:0]     mul_lo,
  input  logic [W-1:0]     mul_hi
);
  seq_state_t       state;
  logic [LEN_W-1:0] len_r;
  logic [LEN_W-1:0] idx_r;
  logic [W-1:0]     mult_r;
  logic [W-1:0]     carry_r;
  logic [W-1:0]     res_r;
  logic             done_r;

  wire last_limb = (idx_r == len_r - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      len_r   <= '0;
      idx_r   <= '0;
      mult_r  <= '0;
      carry_r <= '0;
      res_r   <= '0;
      done_r  <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (start) begin
            len_r   <= len;
            idx_r   <= '0;
            mult_r  <= mult;
            carry_r <= cin;
            if (len == '0) begin
              done_r <= 1'b1;
            end else begin
              done_r <= 1'b0;
              state  <= S_FETCH;
            end
          end
        end
        S_FETCH: begin
          if (in_valid) state <= S_MUL;
        end
        S_MUL: begin
          if (mul_rdy) begin
            res_r   <= mul_lo;
            carry_r <= mul_hi;
            state   <= S_EMIT;
          end
        end
        S_EMIT: begin
          if (out_ready) begin
            idx_r <= idx_r + LEN_W'(1);
            if (last_limb) begin
              done_r <= 1'b1;
              state  <= S_IDLE;
            end else begin
              state <= S_FETCH;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign in_ready  = (state == S_FETCH);
  assign out_valid = (state == S_EMIT);
  assign out_limb  = res_r;
  assign busy      = (state != S_IDLE);
  assign done      = done_r;
  assign carry_out = carry_r;
  assign mul_go    = in_ready && in_valid;
  assign mul_a     = in_limb;
  assign mul_b     = mult_r;
  assign mul_c     = carry_r;

  // R3: a waiting result is held steady under back-pressure
  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_limb));

  // R4: no new limb is requested while the product unit still works
  p_no_fetch_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !mul_busy);

  // R5: done only rises after a final handover or a zero-length start
  p_done_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(out_valid && out_ready) || $past(start));

  // R6: while idle the returned carry is frozen
  p_carry_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(carry_out));

  // R7: a start during a run leaves the captured multiplier alone
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(mul_b));
endmodule

// File: rtl/limb_mac_seq.sv
module limb_mac_seq #(
  parameter int LIMB_W    = 64,
  parameter int MAX_LIMBS = 16,
  parameter int MUL_LAT   = 3,
  parameter int LEN_W     = $clog2(MAX_LIMBS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  vlen,
  input  logic [LIMB_W-1:0] mult,
  input  logic [LIMB_W-1:0] carry_in,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LIMB_W-1:0] in_limb,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LIMB_W-1:0] out_limb,
  output logic              busy,
  output logic              done,
  output logic [LIMB_W-1:0] carry_out
);
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LIMBS);

  logic [LEN_W-1:0]  len_eff;
  logic              mul_go, mul_busy, mul_rdy;
  logic [LIMB_W-1:0] mul_a, mul_b, mul_c, mul_lo, mul_hi;

  assign len_eff = (vlen > LEN_CAP) ? LEN_CAP : vlen;

  lmac_ctl #(.W(LIMB_W), .LEN_W(LEN_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .len       (len_eff),
    .mult      (mult),
    .cin       (carry_in),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_limb   (in_limb),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_limb  (out_limb),
    .busy      (busy),
    .done      (done),
    .carry_out (carry_out),
    .mul_go    (mul_go),
    .mul_a     (mul_a),
    .mul_b     (mul_b),
    .mul_c     (mul_c),
    .mul_busy  (mul_busy),
    .mul_rdy   (mul_rdy),
    .mul_lo    (mul_lo),
    .mul_hi    (mul_hi)
  );

  lmac_mul #(.W(LIMB_W), .LAT(MUL_LAT)) u_mul (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (mul_go),
    .a    (mul_a),
    .b    (mul_b),
    .c    (mul_c),
    .busy (mul_busy),
    .rdy  (mul_rdy),
    .lo   (mul_lo),
    .hi   (mul_hi)
  );

  // R1: the block leaves reset idle with no stream activity
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> !busy && !done && !in_ready && !out_valid);
endmodule

// File: tb/sim_limb_mac_seq.sv
`timescale 1ns/1ps
module sim_limb_mac_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  vlen = '0;
  logic [63:0] mult = '0, carry_in = '0, in_limb = '0;
  logic        in_valid = 1'b0, out_ready = 1'b0;
  logic        in_ready, out_valid, busy, done;
  logic [63:0] out_limb, carry_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  limb_mac_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen), .mult(mult),
    .carry_in(carry_in), .in_valid(in_valid), .in_ready(in_ready),
    .in_limb(in_limb), .out_valid(out_valid), .out_ready(out_ready),
    .out_limb(out_limb), .busy(busy), .done(done), .carry_out(carry_out)
  );

  localparam int NV = 4;
  localparam logic [4:0]  T_LEN [NV] = '{5'd3, 5'd1, 5'd3, 5'd2};
  localparam logic [63:0] T_MUL [NV] = '{64'h1_0001, 64'h1_0001, {64{1'b1}}, 64'd2};
  localparam logic [63:0] T_CIN [NV] = '{64'hFEDC, 64'hFEDC, {64{1'b1}}, 64'd1};
  localparam logic [63:0] T_A [NV][3] = '{
    '{64'h1357_0000_9BDF_0000, 64'h9ABC_0000_DEF0_0000, 64'h1234_0000_5678_0000},
    '{64'h1357_0000_9BDF_0000, 64'h0, 64'h0},
    '{{64{1'b1}}, {64{1'b1}}, {64{1'b1}}},
    '{64'h8000_0000_0000_0001, 64'h7, 64'h0}};
  localparam logic [63:0] T_Y [NV][3] = '{
    '{64'h1357_9BDF_9BDF_FEDC, 64'h9ABC_DEF0_DEF0_1357, 64'h1234_5678_5678_9ABC},
    '{64'h1357_9BDF_9BDF_FEDC, 64'h0, 64'h0},
    '{64'h0, 64'h0, 64'h0},
    '{64'h3, 64'hF, 64'h0}};
  localparam logic [63:0] T_CO [NV] = '{64'h1234, 64'h1357, {64{1'b1}}, 64'h0};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_start(input logic [4:0] l, input logic [63:0] m, input logic [63:0] c);
    @(negedge clk);
    start = 1'b1; vlen = l; mult = m; carry_in = c;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic feed(input logic [63:0] limb);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_limb = limb;
    @(negedge clk);
    in_valid = 1'b0; in_limb = 64'hDEAD_BEEF_DEAD_BEEF;
  endtask

  task automatic take(input logic [63:0] exp, input int stall);
    logic [63:0] held;
    while (!out_valid) @(negedge clk);
    chk("R4 in_ready low while result waits", {63'b0, in_ready}, 64'd0);
    held = out_limb;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk("R3 out_valid held under stall", {63'b0, out_valid}, 64'd1);
      chk("R3 out_limb stable under stall", out_limb, held);
    end
    chk("R2 result limb", out_limb, exp);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      errors++;
      $display("FAIL R5 watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy after reset", {63'b0, busy}, 64'd0);
    chk("R1 done after reset", {63'b0, done}, 64'd0);
    chk("R1 in_ready after reset", {63'b0, in_ready}, 64'd0);
    chk("R1 out_valid after reset", {63'b0, out_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table
    for (int v = 0; v < NV; v++) begin
      do_start(T_LEN[v], T_MUL[v], T_CIN[v]);
      for (int k = 0; k < int'(T_LEN[v]); k++) begin
        feed(T_A[v][k]);
        take(T_Y[v][k], (k == 1) ? 3 : 0);
      end
      chk("R5 done after last limb", {63'b0, done}, 64'd1);
      chk("R5 busy low after last limb", {63'b0, busy}, 64'd0);
      chk("R5 final carry", carry_out, T_CO[v]);
    end

    // zero length
    do_start(5'd0, 64'h55, 64'hCAFE_F00D);
    chk("R6 done after zero-length start", {63'b0, done}, 64'd1);
    chk("R6 carry unchanged", carry_out, 64'hCAFE_F00D);
    chk("R6 no in_ready", {63'b0, in_ready}, 64'd0);
    repeat (3) @(negedge clk);
    chk("R6 still no in_ready", {63'b0, in_ready}, 64'd0);

    // start while busy is ignored
    do_start(5'd3, 64'h1_0001, 64'hFEDC);
    feed(T_A[0][0]);
    start = 1'b1; vlen = 5'd0; mult = 64'h7777; carry_in = 64'hAAAA;
    @(negedge clk);
    start = 1'b0;
    chk("R7 done low after ignored start", {63'b0, done}, 64'd0);
    chk("R7 busy kept", {63'b0, busy}, 64'd1);
    take(T_Y[0][0], 0);
    for (int k = 1; k < 3; k++) begin
      feed(T_A[0][k]);
      take(T_Y[0][k], 0);
    end
    chk("R7 final carry unaffected", carry_out, 64'h1234);

    // length clamp
    begin
      logic [63:0] cr;
      logic [127:0] full;
      int n_out;
      cr = 64'd5;
      n_out = 0;
      do_start(5'd20, 64'h3000_0000_0000_0003, cr);
      for (int k = 0; k < 16; k++) begin
        full = 128'(64'h8000_0000_0000_0000 + 64'(k)) * 128'(64'h3000_0000_0000_0003) + 128'(cr);
        feed(64'h8000_0000_0000_0000 + 64'(k));
        take(full[63:0], 0);
        cr = full[127:64];
        n_out++;
      end
      chk("R8 done after 16 limbs", {63'b0, done}, 64'd1);
      chk("R8 no further in_ready", {63'b0, in_ready}, 64'd0);
      chk("R8 limb count", 64'(n_out), 64'd16);
      chk("R8 final carry", carry_out, cr);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule